// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block is the cycle engine of a four-channel DMA controller. The register front end holds the per-channel configuration, the base address, base count and page byte. It hands these over as flat buses, together with one-cycle command pulses: copy base to current, set mask, clear mask, software request and clear status flags. Each clock, the engine picks at most one eligible channel in fixed priority order. During that cycle it drives the channel's acknowledge, the 24-bit memory address and a memory read or write strobe. At the clock edge that closes the cycle, it steps the channel's current address and count.

A channel ends a transfer in one of two ways: its count wraps below zero (terminal count), or the external end-of-process input is asserted while the channel is being served. On either event the engine sets the channel's status flag and drops its software request. On terminal count only, it then either reloads the current registers from the base registers or masks the channel. The channel's mode decides how DREQ is read: one cycle per request, a cycle every clock while the request is held, or a whole run that continues once started. A parameter selects a word-wide variant, in which the current address counts 16-bit words.

Top module: `dma_xfer_engine`

## Requirements
- R1: After synchronous reset, `dack`, `mem_wr`, `mem_rd` and `tc_out` are 0, every bit of `masks` is 1 and every bit of `flags` is 0.
- R2: While `cmd_disable` is 1, no channel is acknowledged. A software request made in that time stays pending and is served once `cmd_disable` returns to 0.
- R3: A channel whose configuration bits 5:4 are 11 (cascade) is never acknowledged, even when it has an unmasked DREQ or a software request.
- R4: DREQ makes a channel eligible only while its mask bit is 0. A software request makes it eligible whatever the mask, and keeps it eligible until terminal count or end-of-process.
- R5: Channel 0 has the highest priority and channel 3 the lowest. At most one `dack` bit is high per clock. `dack`, `mem_addr`, the strobes and `tc_out` belong to the cycle in which they are shown, and the counters change at the clock edge that ends that cycle.
- R6: Each served cycle steps the current address by +1, or by -1 when configuration bit 3 is 1, and decrements the current count. `tc_out` is high in the cycle whose current count is 0, so a programmed count N gives N+1 cycles.
- R7: Terminal count, or `eop_in` high in a served cycle, sets that channel's `flags` bit and clears its software request. `eop_in` also stops a block run. `flag_clr` clears all flags, except when a terminal event in the same cycle sets one.
- R8: On terminal count, when configuration bit 2 (auto-reload) is 1, the current address and count are reloaded from the base values. When bit 2 is 0, the channel's mask bit is set. An end-of-process without terminal count does neither.
- R9: Configuration bits 5:4 select the mode. 00 (demand) gives one cycle per clock while DREQ is held. 01 (single) gives one cycle, after which DREQ must drop before the next cycle. 10 (block) goes on after DREQ drops, until terminal count or end-of-process.
- R10: Configuration bits 1:0 select the transfer type. 01 pulses `mem_wr` (device to memory) and 10 pulses `mem_rd` (memory to device). 00 and 11 give no strobe, but the counters still step.
- R11: With WIDE=0, `mem_addr` is {page, current address}. With WIDE=1, it is {page, current address shifted left by one and cut to 16 bits}.
- R12: A `ld_cur` pulse copies the base address and base count of that channel into its current registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_disable | input | 1 | Controller disable from the command register |
| cfg_bus | input | NCH*6 | Per-channel configuration: [5:4] mode, [3] down, [2] auto-reload, [1:0] type |
| base_addr_bus | input | NCH*AW | Per-channel base address |
| base_cnt_bus | input | NCH*CW | Per-channel base count |
| page_bus | input | NCH*PW | Per-channel page byte |
| ld_cur | input | NCH | Copy base values to current registers |
| mask_set | input | NCH | Set mask bits |
| mask_clr | input | NCH | Clear mask bits |
| swreq_set | input | NCH | Raise software requests |
| flag_clr | input | 1 | Clear all status flags |
| dreq | input | NCH | Device requests |
| eop_in | input | 1 | External end-of-process for the served channel |
| dack | output | NCH | One-hot acknowledge of the served channel |
| mem_addr | output | PW+AW | Physical memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| tc_out | output | 1 | Terminal count in this cycle |
| flags | output | NCH | Terminal-count or end-of-process status |
| masks | output | NCH | Current mask bits |

## Verification
A wrong current count shows up as a run that is one or more cycles too long or too short, and as `tc_out` pulsing in the wrong cycle. A wrong step direction or a wrong reload shows in `mem_addr` already in the next served cycle. A mode state left set by mistake, such as a stuck single-mode hold or a block run that does not end, shows as missing or extra `dack` cycles within a few clocks of DREQ changing. A wrong end-of-transfer action shows in `masks` and `flags` in the cycle after the final transfer.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int CFG_W = 6;

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_BLOCK   = 2'b10,
        XM_CASCADE = 2'b11
    } xmode_e;

    typedef enum logic [1:0] {
        XT_VERIFY   = 2'b00,
        XT_TO_MEM   = 2'b01,
        XT_FROM_MEM = 2'b10,
        XT_BAD      = 2'b11
    } xtype_e;

    typedef struct packed {
        xmode_e run_mode;
        logic   down;
        logic   auto_ld;
        xtype_e xtype;
    } chan_cfg_t;

endpackage

// File: rtl/dma_fixed_prio.sv
module dma_fixed_prio #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
    parameter int AW   = 16,
    parameter int PW   = 8,
    parameter bit WIDE = 1'b0
) (
    input  logic [PW-1:0]    page,
    input  logic [AW-1:0]    word,
    output logic [PW+AW-1:0] phys
);
    generate
        if (WIDE) begin : g_wide
            assign phys = {page, word << 1};
        end else begin : g_narrow
            assign phys = {page, word};
        end
    endgenerate
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  xmode_e        run_mode,
    input  logic          down,
    input  logic          auto_ld,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] base_cnt,
    input  logic          ld,
    input  logic          mset,
    input  logic          mclr,
    input  logic          sreq_set,
    input  logic          flag_clr,
    input  logic          dreq,
    input  logic          eop,
    input  logic          gnt,
    output logic          want,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic          mask_q,
    output logic          flag_q
);
    logic sreq_q, run_q, hold_q, last;

    assign last = (cur_cnt == '0);

    always_comb begin
        want = 1'b0;
        if (run_mode != XM_CASCADE) begin
            if (sreq_q) want = 1'b1;
            else begin
                case (run_mode)
                    XM_DEMAND: want = dreq && !mask_q;
                    XM_SINGLE: want = dreq && !mask_q && !hold_q;
                    XM_BLOCK:  want = run_q || (dreq && !mask_q);
                    default:   want = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            mask_q   <= 1'b1;
            flag_q   <= 1'b0;
            sreq_q   <= 1'b0;
            run_q    <= 1'b0;
            hold_q   <= 1'b0;
        end else begin
            if (mclr)     mask_q <= 1'b0;
            if (mset)     mask_q <= 1'b1;
            if (flag_clr) flag_q <= 1'b0;
            if (sreq_set) sreq_q <= 1'b1;
            if (!dreq)    hold_q <= 1'b0;
            if (gnt) begin
                cur_addr <= down ? cur_addr - AW'(1) : cur_addr + AW'(1);
                cur_cnt  <= cur_cnt - CW'(1);
                hold_q   <= (run_mode == XM_SINGLE);
                if (last || eop) begin
                    flag_q <= 1'b1;
                    sreq_q <= 1'b0;
                    run_q  <= 1'b0;
                end else begin
                    run_q <= (run_mode == XM_BLOCK);
                end
                if (last) begin
                    if (auto_ld) begin
                        cur_addr <= base_addr;
                        cur_cnt  <= base_cnt;
                    end else begin
                        mask_q <= 1'b1;
                    end
                end
            end
            if (ld) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end
        end
    end

    AST_CASCADE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (run_mode == XM_CASCADE) |-> !gnt); // R3
    AST_MASK_ON_END: assert property (@(posedge clk) disable iff (rst)
        (gnt && last && !auto_ld) |=> mask_q); // R8
    AST_RELOAD_ON_END: assert property (@(posedge clk) disable iff (rst)
        (gnt && last && auto_ld) |=> (cur_cnt == $past(base_cnt))); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (gnt && !(last && auto_ld) && !ld) |=>
        (cur_addr == AW'($past(cur_addr) + ($past(down) ? {AW{1'b1}} : AW'(1))))); // R6
    AST_FLAG_ON_END: assert property (@(posedge clk) disable iff (rst)
        (gnt && (last || eop)) |=> flag_q); // R7
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int PW   = 8,
    parameter bit WIDE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_disable,
    input  logic [NCH*CFG_W-1:0] cfg_bus,
    input  logic [NCH*AW-1:0]    base_addr_bus,
    input  logic [NCH*CW-1:0]    base_cnt_bus,
    input  logic [NCH*PW-1:0]    page_bus,
    input  logic [NCH-1:0]       ld_cur,
    input  logic [NCH-1:0]       mask_set,
    input  logic [NCH-1:0]       mask_clr,
    input  logic [NCH-1:0]       swreq_set,
    input  logic                 flag_clr,
    input  logic [NCH-1:0]       dreq,
    input  logic                 eop_in,
    output logic [NCH-1:0]       dack,
    output logic [PW+AW-1:0]     mem_addr,
    output logic                 mem_wr,
    output logic                 mem_rd,
    output logic                 tc_out,
    output logic [NCH-1:0]       flags,
    output logic [NCH-1:0]       masks
);
    chan_cfg_t       cfg_a  [NCH];
    logic [AW-1:0]   addr_a [NCH];
    logic [CW-1:0]   cnt_a  [NCH];
    logic [NCH-1:0]  want;
    logic [AW-1:0]   sel_addr;
    logic [CW-1:0]   sel_cnt;
    logic [PW-1:0]   sel_page;
    xtype_e          sel_type;
    logic            busy;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign cfg_a[i] = chan_cfg_t'(cfg_bus[i*CFG_W +: CFG_W]);
            dma_chan_slot #(.AW(AW), .CW(CW)) u_slot (
                .clk      (clk),
                .rst      (rst),
                .run_mode (cfg_a[i].run_mode),
                .down     (cfg_a[i].down),
                .auto_ld  (cfg_a[i].auto_ld),
                .base_addr(base_addr_bus[i*AW +: AW]),
                .base_cnt (base_cnt_bus[i*CW +: CW]),
                .ld       (ld_cur[i]),
                .mset     (mask_set[i]),
                .mclr     (mask_clr[i]),
                .sreq_set (swreq_set[i]),
                .flag_clr (flag_clr),
                .dreq     (dreq[i]),
                .eop      (eop_in),
                .gnt      (dack[i]),
                .want     (want[i]),
                .cur_addr (addr_a[i]),
                .cur_cnt  (cnt_a[i]),
                .mask_q   (masks[i]),
                .flag_q   (flags[i])
            );
        end
    endgenerate

    dma_fixed_prio #(.N(NCH)) u_prio (
        .en (!cmd_disable),
        .req(want),
        .gnt(dack)
    );

    always_comb begin
        sel_addr = '0;
        sel_cnt  = '0;
        sel_page = '0;
        sel_type = XT_VERIFY;
        for (int i = 0; i < NCH; i++) begin
            if (dack[i]) begin
                sel_addr = addr_a[i];
                sel_cnt  = cnt_a[i];
                sel_page = page_bus[i*PW +: PW];
                sel_type = cfg_a[i].xtype;
            end
        end
    end

    dma_addr_form #(.AW(AW), .PW(PW), .WIDE(WIDE)) u_addr (
        .page(sel_page),
        .word(sel_addr),
        .phys(mem_addr)
    );

    assign busy   = |dack;
    assign mem_wr = busy && (sel_type == XT_TO_MEM);
    assign mem_rd = busy && (sel_type == XT_FROM_MEM);
    assign tc_out = busy && (sel_cnt == '0);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack)); // R5
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |-> (dack == '0)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> ((dack != '0) && !(mem_rd && mem_wr))); // R10
endmodule

// File: tb/sim_dma_xfer_engine.sv
module sim_dma_xfer_engine;
    localparam int CLK_PER = 10;
    localparam int NCH = 4;
    localparam int WD_LIMIT = 20000;

    typedef struct packed {
        logic [5:0]  mode;
        logic [15:0] addr;
        logic [15:0] cnt;
        logic [7:0]  page;
        logic [7:0]  n;
        logic [23:0] first;
        logic [23:0] last;
        logic [23:0] wfirst;
        logic        wr;
        logic        rd;
        logic        msk;
    } vec_t;

    // mode fields: [5:4] mode, [3] down, [2] auto, [1:0] type
    localparam vec_t TBL [5] = '{
        '{6'h11, 16'h1000, 16'd3, 8'h12, 8'd4, 24'h121000, 24'h121003, 24'h122000, 1'b1, 1'b0, 1'b1},
        '{6'h1A, 16'h0005, 16'd2, 8'h00, 8'd3, 24'h000005, 24'h000003, 24'h00000A, 1'b0, 1'b1, 1'b1},
        '{6'h14, 16'hFFFE, 16'd2, 8'h7F, 8'd3, 24'h7FFFFE, 24'h7F0000, 24'h7FFFFC, 1'b0, 1'b0, 1'b0},
        '{6'h21, 16'h0100, 16'd0, 8'h01, 8'd1, 24'h010100, 24'h010100, 24'h010200, 1'b1, 1'b0, 1'b1},
        '{6'h13, 16'h0020, 16'd1, 8'h30, 8'd2, 24'h300020, 24'h300021, 24'h300040, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_disable = 1'b0;
    logic [NCH*6-1:0]  cfg_bus = '0;
    logic [NCH*16-1:0] base_addr_bus = '0;
    logic [NCH*16-1:0] base_cnt_bus = '0;
    logic [NCH*8-1:0]  page_bus = '0;
    logic [NCH-1:0] ld_cur = '0, mask_set = '0, mask_clr = '0, swreq_set = '0, dreq = '0;
    logic flag_clr = 1'b0, eop_in = 1'b0;
    logic [NCH-1:0] dack, flags, masks, dack1, flags1, masks1;
    logic [23:0] mem_addr, mem_addr1;
    logic mem_wr, mem_rd, tc_out, mem_wr1, mem_rd1, tc_out1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    dma_xfer_engine u0 (
        .clk(clk), .rst(rst), .cmd_disable(cmd_disable), .cfg_bus(cfg_bus),
        .base_addr_bus(base_addr_bus), .base_cnt_bus(base_cnt_bus), .page_bus(page_bus),
        .ld_cur(ld_cur), .mask_set(mask_set), .mask_clr(mask_clr), .swreq_set(swreq_set),
        .flag_clr(flag_clr), .dreq(dreq), .eop_in(eop_in), .dack(dack), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .tc_out(tc_out), .flags(flags), .masks(masks)
    );

    dma_xfer_engine #(.WIDE(1'b1)) u1 (
        .clk(clk), .rst(rst), .cmd_disable(cmd_disable), .cfg_bus(cfg_bus),
        .base_addr_bus(base_addr_bus), .base_cnt_bus(base_cnt_bus), .page_bus(page_bus),
        .ld_cur(ld_cur), .mask_set(mask_set), .mask_clr(mask_clr), .swreq_set(swreq_set),
        .flag_clr(flag_clr), .dreq(dreq), .eop_in(eop_in), .dack(dack1), .mem_addr(mem_addr1),
        .mem_wr(mem_wr1), .mem_rd(mem_rd1), .tc_out(tc_out1), .flags(flags1), .masks(masks1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input int ch, input logic [5:0] m, input logic [15:0] a,
                        input logic [15:0] c, input logic [7:0] p, input bit unmask);
        tick();
        cfg_bus[ch*6 +: 6]        = m;
        base_addr_bus[ch*16 +: 16] = a;
        base_cnt_bus[ch*16 +: 16]  = c;
        page_bus[ch*8 +: 8]        = p;
        ld_cur[ch]   = 1'b1;
        mask_clr[ch] = unmask;
        tick();
        ld_cur   = '0;
        mask_clr = '0;
    endtask

    task automatic pulse_swreq(input int ch);
        tick();
        swreq_set[ch] = 1'b1;
        tick();
        swreq_set = '0;
    endtask

    task automatic pulse_flag_clr();
        tick();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic count_dack(input int ch, input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (dack[ch]) c++;
        end
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c, c2;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 dack after reset", 32'(dack), 0);
        chk("R1 strobes after reset", {30'd0, mem_wr, mem_rd}, 0);
        chk("R1 masks after reset", 32'(masks), 32'hF);
        chk("R1 flags after reset", 32'(flags), 0);
        chk("R1 tc_out after reset", 32'(tc_out), 0);

        // Table: software-request runs on channel 1
        for (int k = 0; k < 5; k++) begin
            int n;
            logic [23:0] fa, la, wfa;
            logic sw, sr, tcs;
            load(1, TBL[k].mode, TBL[k].addr, TBL[k].cnt, TBL[k].page, 1'b1);
            pulse_flag_clr();
            pulse_swreq(1);
            n = 0; fa = '0; la = '0; wfa = '0; sw = 0; sr = 0; tcs = 0;
            for (int j = 0; j < 12; j++) begin
                @(negedge clk);
                if (dack[1]) begin
                    n++;
                    if (n == 1) begin
                        fa  = mem_addr;
                        wfa = mem_addr1;
                    end
                    la  = mem_addr;
                    sw |= mem_wr;
                    sr |= mem_rd;
                    tcs = tc_out;
                end
            end
            chk($sformatf("R6 entry %0d cycle count", k), n, 32'(TBL[k].n));
            chk($sformatf("R12 entry %0d first address", k), 32'(fa), 32'(TBL[k].first));
            chk($sformatf("R6 entry %0d last address", k), 32'(la), 32'(TBL[k].last));
            chk($sformatf("R11 entry %0d wide first address", k), 32'(wfa), 32'(TBL[k].wfirst));
            chk($sformatf("R10 entry %0d write strobe", k), 32'(sw), 32'(TBL[k].wr));
            chk($sformatf("R10 entry %0d read strobe", k), 32'(sr), 32'(TBL[k].rd));
            chk($sformatf("R6 entry %0d tc_out on last", k), 32'(tcs), 1);
            chk($sformatf("R7 entry %0d flag", k), 32'(flags[1]), 1);
            chk($sformatf("R8 entry %0d mask after end", k), 32'(masks[1]), 32'(TBL[k].msk));
        end

        // R5 fixed priority
        load(0, 6'h01, 16'h0000, 16'd50, 8'h00, 1'b1);
        load(2, 6'h01, 16'h0200, 16'd50, 8'h00, 1'b1);
        tick(); dreq = 4'b0101;
        @(negedge clk);
        chk("R5 ch0 over ch2", 32'(dack), 32'h1);
        tick(); dreq = 4'b0100;
        @(negedge clk);
        chk("R5 ch2 alone", 32'(dack), 32'h4);
        tick(); dreq = '0;

        // R9 single mode
        load(0, 6'h11, 16'h0000, 16'd100, 8'h00, 1'b1);
        tick(); dreq[0] = 1'b1;
        count_dack(0, 5, c);
        chk("R9 single mode one cycle per request", c, 1);
        tick(); dreq[0] = 1'b0;
        count_dack(0, 1, c);
        tick(); dreq[0] = 1'b1;
        count_dack(0, 3, c);
        chk("R9 single mode serves new request", c, 1);
        tick(); dreq[0] = 1'b0;

        // R9 demand mode
        load(0, 6'h01, 16'h0000, 16'd100, 8'h00, 1'b1);
        tick(); dreq[0] = 1'b1;
        count_dack(0, 3, c);
        tick(); dreq[0] = 1'b0;
        count_dack(0, 4, c2);
        chk("R9 demand mode follows dreq", c + c2, 3);

        // R7 end-of-process in block mode
        load(0, 6'h21, 16'h0000, 16'd100, 8'h00, 1'b1);
        pulse_flag_clr();
        tick(); dreq[0] = 1'b1;
        count_dack(0, 1, c);
        tick(); dreq[0] = 1'b0;
        count_dack(0, 1, c2);
        c += c2;
        tick(); eop_in = 1'b1;
        count_dack(0, 1, c2);
        c += c2;
        tick(); eop_in = 1'b0;
        count_dack(0, 5, c2);
        chk("R7 eop stops block run", c + c2, 3);
        chk("R7 eop sets flag", 32'(flags[0]), 1);
        chk("R8 eop leaves mask clear", 32'(masks[0]), 0);
        pulse_flag_clr();
        @(negedge clk);
        chk("R7 flag_clr clears flags", 32'(flags), 0);

        // R9 block mode runs to terminal count
        load(0, 6'h21, 16'h0040, 16'd5, 8'h00, 1'b1);
        tick(); dreq[0] = 1'b1;
        count_dack(0, 1, c);
        tick(); dreq[0] = 1'b0;
        count_dack(0, 12, c2);
        chk("R9 block mode runs after dreq drops", c + c2, 6);
        chk("R8 mask set at terminal count", 32'(masks[0]), 1);

        // R2 disable holds a software request
        load(1, 6'h01, 16'h0300, 16'd1, 8'h00, 1'b0);
        tick(); cmd_disable = 1'b1;
        pulse_swreq(1);
        count_dack(1, 4, c);
        chk("R2 no dack while disabled", c, 0);
        tick(); cmd_disable = 1'b0;
        count_dack(1, 6, c);
        chk("R2 request served after enable", c, 2);

        // R4 masked dreq ignored, software request ignores mask
        load(3, 6'h01, 16'h0400, 16'd0, 8'h00, 1'b0);
        tick(); dreq[3] = 1'b1;
        count_dack(3, 3, c);
        chk("R4 masked dreq ignored", c, 0);
        tick(); dreq[3] = 1'b0;
        pulse_swreq(3);
        count_dack(3, 4, c);
        chk("R4 software request ignores mask", c, 1);

        // R3 cascade channel never served
        load(2, 6'h30, 16'h0500, 16'd3, 8'h00, 1'b1);
        tick(); dreq[2] = 1'b1;
        pulse_swreq(2);
        count_dack(2, 4, c);
        chk("R3 cascade channel idle", c, 0);
        chk("R3 no dack at all", 32'(dack), 0);
        tick(); dreq = '0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule